// File: doc/BRIEF.md
# Four-Channel Output Compare Unit

This block watches an external free-running 16-bit count and compares it with four per-channel compare values. Each channel that software selects for output compare owns one pin. On a compare event the channel applies its programmed pin action (leave, toggle, drive low or drive high) and raises its event flag. The flag stays set until software writes a 1 to it. Software can also fire a channel's action at once through a strobe register. A forced action never raises the flag.

Channel 3 is the master channel. Whenever it fires, whether from a match or from the strobe, every pin whose bit is set in a master mask register takes the matching bit of a master data register. This load beats any action on the same pin in the same cycle. All configuration sits behind a byte-wide register bus with single-cycle writes and combinational reads.

Top module: `oc_quad`

## Requirements
- R1: After reset every register reads 0, and all pins, output enables and flags are 0.
- R2: Register map (4-bit address). 0 = channel select (bit n selects channel n for output compare). 1 = actions (channel n in bits 2n+1:2n). 2 = force strobe, which always reads 0. 3 = master mask. 4 = master data. 5 = flags. Compare value n sits at 8+2n (low byte) and 9+2n (high byte). The mask and data registers keep bits 3:0 and read 7:4 as 0.
- R3: A selected channel has a compare event only in the cycle in which the count changes to a value equal to its compare value. A count held at that value gives no further event. An unselected channel has no event.
- R4: Action codes are 00 leave pin unchanged, 01 toggle, 10 drive low, and 11 drive high. The pin is updated at the clock edge on which the event is seen.
- R5: A compare event sets the channel's flag. Writing 1 to a flag bit at address 5 clears it, and writing 0 leaves it unchanged.
- R6: Writing 1 to bit n of the force strobe applies channel n's action at that edge (selected channels only) and leaves its flag unchanged.
- R7: A forced action and a real event on the same channel in the same cycle apply the action once and do not set the flag.
- R8: When channel 3 fires, each pin n with mask bit n set takes data bit n. This overrides that pin's own action in the same cycle.
- R9: Pin n is enabled only if channel n is selected and either its action is not 00 or (for n < 3) its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| cnt | input | 16 | Free-running count |
| pin_out | output | 4 | Pin levels |
| pin_oe | output | 4 | Pin output enables |
| irq | output | 4 | Per-channel event flags |

## Verification
Several properties are checked on every cycle. A flag never rises without a real, unforced event in the previous cycle. A master event always leaves the masked pins equal to the data bits sampled with it. An enable never appears on an unselected channel. The strobe address always reads 0. Only the bench scenarios can show the following: that each action code gives the right pin level, that a held count fires once, that write-one-to-clear works, and the exact outcome when a force, a match and a master load meet in one cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int NCH    = 4;
    localparam int CNT_W  = 16;
    localparam int DW     = 8;
    localparam int AW     = 4;
    localparam int MST    = NCH - 1;
    localparam int ACT_W  = 2 * NCH;

    localparam logic [AW-1:0] A_SEL = 4'd0;
    localparam logic [AW-1:0] A_ACT = 4'd1;
    localparam logic [AW-1:0] A_FRC = 4'd2;
    localparam logic [AW-1:0] A_MSK = 4'd3;
    localparam logic [AW-1:0] A_DAT = 4'd4;
    localparam logic [AW-1:0] A_FLG = 4'd5;
    localparam int            A_CMP = 8;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;
endpackage

// File: rtl/oc_regs.sv
module oc_regs
    import oc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [NCH-1:0]       flag_set,
    output logic [NCH-1:0]       ocsel,
    output logic [ACT_W-1:0]     act,
    output logic [NCH-1:0]       fstrobe,
    output logic [NCH-1:0]       mmask,
    output logic [NCH-1:0]       mdata,
    output logic [NCH-1:0]       irq,
    output logic [NCH*CNT_W-1:0] cmp
);
    logic [NCH-1:0] flag_clr;

    assign fstrobe  = (wr_en && addr == A_FRC) ? wdata[NCH-1:0] : '0;
    assign flag_clr = (wr_en && addr == A_FLG) ? wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ocsel <= '0;
            act   <= '0;
            mmask <= '0;
            mdata <= '0;
            irq   <= '0;
        end else begin
            if (wr_en && addr == A_SEL) ocsel <= wdata[NCH-1:0];
            if (wr_en && addr == A_ACT) act   <= wdata[ACT_W-1:0];
            if (wr_en && addr == A_MSK) mmask <= wdata[NCH-1:0];
            if (wr_en && addr == A_DAT) mdata <= wdata[NCH-1:0];
            irq <= (irq & ~flag_clr) | flag_set;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_cmp
        localparam logic [AW-1:0] LO = AW'(A_CMP + 2 * n);
        localparam logic [AW-1:0] HI = AW'(A_CMP + 2 * n + 1);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp[n*CNT_W +: CNT_W] <= '0;
            end else if (wr_en) begin
                if (addr == LO) cmp[n*CNT_W +: 8]     <= wdata;
                if (addr == HI) cmp[n*CNT_W + 8 +: 8] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_SEL:   rdata = DW'(ocsel);
            A_ACT:   rdata = act;
            A_FRC:   rdata = '0;
            A_MSK:   rdata = DW'(mmask);
            A_DAT:   rdata = DW'(mdata);
            A_FLG:   rdata = DW'(irq);
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (addr == AW'(A_CMP + 2 * n))     rdata = cmp[n*CNT_W +: 8];
                    if (addr == AW'(A_CMP + 2 * n + 1)) rdata = cmp[n*CNT_W + 8 +: 8];
                end
            end
        endcase
    end
endmodule

// File: rtl/oc_match.sv
module oc_match
    import oc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [NCH*CNT_W-1:0] cmp,
    input  logic [NCH-1:0]       ocsel,
    output logic [NCH-1:0]       real_ev
);
    logic [CNT_W-1:0] cnt_q;
    logic             moved;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt;
    end

    assign moved = (cnt != cnt_q);

    for (genvar n = 0; n < NCH; n++) begin : g_eq
        assign real_ev[n] = ocsel[n] && moved && (cnt == cmp[n*CNT_W +: CNT_W]);
    end
endmodule

// File: rtl/oc_pins.sv
module oc_pins
    import oc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ev_any,
    input  logic [ACT_W-1:0] act,
    input  logic [NCH-1:0]   ocsel,
    input  logic [NCH-1:0]   mmask,
    input  logic [NCH-1:0]   mdata,
    output logic [NCH-1:0]   pin_out,
    output logic [NCH-1:0]   pin_oe
);
    logic [NCH-1:0] pin_nxt;
    logic           mst_fire;

    function automatic logic apply_act(input act_e a, input logic cur);
        logic r;
        unique case (a)
            ACT_KEEP: r = cur;
            ACT_TOG:  r = ~cur;
            ACT_LOW:  r = 1'b0;
            ACT_HIGH: r = 1'b1;
        endcase
        return r;
    endfunction

    assign mst_fire = ev_any[MST];

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            pin_nxt[n] = pin_out[n];
            if (ev_any[n])
                pin_nxt[n] = apply_act(act_e'(act[2*n +: 2]), pin_out[n]);
            if (mst_fire && mmask[n])
                pin_nxt[n] = mdata[n];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_out <= '0;
        else        pin_out <= pin_nxt;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_oe
        if (n == MST) begin : g_mst
            assign pin_oe[n] = ocsel[n] && (act[2*n +: 2] != ACT_KEEP);
        end else begin : g_slv
            assign pin_oe[n] = ocsel[n] && ((act[2*n +: 2] != ACT_KEEP) || mmask[n]);
        end
    end
endmodule

// File: rtl/oc_quad.sv
module oc_quad
    import oc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [CNT_W-1:0] cnt,
    output logic [NCH-1:0]   pin_out,
    output logic [NCH-1:0]   pin_oe,
    output logic [NCH-1:0]   irq
);
    logic [NCH-1:0]       ocsel, fstrobe, mmask, mdata;
    logic [NCH-1:0]       real_ev, force_ev, ev_any, flag_set;
    logic [ACT_W-1:0]     act;
    logic [NCH*CNT_W-1:0] cmp;
    logic                 master_ev;

    assign force_ev  = fstrobe & ocsel;
    assign ev_any    = real_ev | force_ev;
    assign flag_set  = real_ev & ~force_ev;
    assign master_ev = ev_any[MST];

    oc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .flag_set(flag_set), .ocsel(ocsel), .act(act),
        .fstrobe(fstrobe), .mmask(mmask), .mdata(mdata), .irq(irq), .cmp(cmp)
    );

    oc_match u_match (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp), .ocsel(ocsel),
        .real_ev(real_ev)
    );

    oc_pins u_pins (
        .clk(clk), .rst_n(rst_n), .ev_any(ev_any), .act(act), .ocsel(ocsel),
        .mmask(mmask), .mdata(mdata), .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/oc_quad_chk.sv
module oc_quad_chk
    import oc_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  addr,
    input logic [DW-1:0]  rdata,
    input logic [NCH-1:0] ocsel,
    input logic [NCH-1:0] real_ev,
    input logic [NCH-1:0] force_ev,
    input logic           master_ev,
    input logic [NCH-1:0] mmask,
    input logic [NCH-1:0] mdata,
    input logic [NCH-1:0] pin_out,
    input logic [NCH-1:0] pin_oe,
    input logic [NCH-1:0] irq
);
    // R3 / R5: a flag rises only after an unforced real event
    p_flag_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq & ~$past(irq) & ~$past(real_ev)) == '0));

    // R6 / R7: a forced action never raises a flag
    p_force_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq & ~$past(irq) & $past(force_ev)) == '0));

    // R8: masked pins follow the master data after a master event
    p_master_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        master_ev |=> (((pin_out ^ $past(mdata)) & $past(mmask)) == '0));

    // R9: no enable on an unselected channel
    p_oe_needs_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~ocsel) == '0);

    // R2: the strobe address always reads zero
    p_force_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_FRC) |-> (rdata == '0));
endmodule

bind oc_quad oc_quad_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .ocsel(ocsel),
    .real_ev(real_ev), .force_ev(force_ev), .master_ev(master_ev),
    .mmask(mmask), .mdata(mdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/sim_oc_quad.sv
module sim_oc_quad;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] cnt = '0;
    logic [3:0]  pin_out, pin_oe, irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    oc_quad u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt(cnt), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {count, expected pins, expected flags}
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {16'd5,  4'b0000, 4'b0000},
        {16'd10, 4'b0001, 4'b0001},
        {16'd10, 4'b0001, 4'b0001},
        {16'd11, 4'b0001, 4'b0001},
        {16'd20, 4'b0011, 4'b0011},
        {16'd30, 4'b0111, 4'b0111},
        {16'd40, 4'b1010, 4'b1111}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; #1;
        d = rdata;
    endtask

    task automatic step(input logic [15:0] c);
        @(negedge clk);
        cnt = c;
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, d); chk("R1 sel", 16'(d), 16'h0);
        rd(4'd1, d); chk("R1 act", 16'(d), 16'h0);
        rd(4'd5, d); chk("R1 flags", 16'(d), 16'h0);
        rd(4'd14, d); chk("R1 cmp", 16'(d), 16'h0);
        chk("R1 pins/oe", {8'h0, pin_out, pin_oe}, 16'h0);

        // setup: all selected; ch0 tog, ch1 tog, ch2 high, ch3 tog
        wr(4'd0, 8'h0F);
        wr(4'd1, 8'h75);
        wr(4'd8, 8'd10);  wr(4'd10, 8'd20);
        wr(4'd12, 8'd30); wr(4'd14, 8'd40);
        wr(4'd3, 8'h05);  wr(4'd4, 8'h08);
        chk("R9 oe all", 16'(pin_oe), 16'hF);

        // R3 R4 R5 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][23:8]);
            chk("R4 pins", 16'(pin_out), 16'(VEC[i][7:4]));
            chk("R3 flags", 16'(irq), 16'(VEC[i][3:0]));
        end

        // R5 write-one-to-clear
        wr(4'd5, 8'h03);
        chk("R5 clear", 16'(irq), 16'hC);

        // R6 force ch0: toggles, flag untouched
        wr(4'd2, 8'h01);
        chk("R6 pins", 16'(pin_out), 16'hB);
        chk("R6 flags", 16'(irq), 16'hC);
        rd(4'd2, d); chk("R2 force reads 0", 16'(d), 16'h0);

        // R7 force and real match on ch0 in one cycle
        @(negedge clk);
        cnt = 16'd10; addr = 4'd2; wdata = 8'h01; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R7 pins", 16'(pin_out), 16'hA);
        chk("R7 flags", 16'(irq), 16'hC);

        // R8 master overrides ch0 action in same cycle
        wr(4'd8, 8'd60); wr(4'd14, 8'd60);
        step(16'd60);
        chk("R8 pins", 16'(pin_out), 16'h2);
        chk("R8 flags", 16'(irq), 16'hD);

        // R3 unselected channel has no event; R9 oe drops
        wr(4'd0, 8'h0E);
        chk("R9 oe unsel", 16'(pin_oe), 16'hE);
        wr(4'd5, 8'h0F);
        chk("R5 clear all", 16'(irq), 16'h0);
        wr(4'd8, 8'd70);
        step(16'd70);
        chk("R3 unsel flag", 16'(irq), 16'h0);
        chk("R3 unsel pin", 16'(pin_out), 16'h2);

        // R9 mask-only enable
        wr(4'd1, 8'h71);
        chk("R9 act off", 16'(pin_oe), 16'hC);
        wr(4'd3, 8'h07);
        chk("R9 mask on", 16'(pin_oe), 16'hE);

        // R2 register widths
        wr(4'd3, 8'hFF);
        rd(4'd3, d); chk("R2 mask", 16'(d), 16'h0F);
        wr(4'd4, 8'hF3);
        rd(4'd4, d); chk("R2 data", 16'(d), 16'h03);
        rd(4'd9, d); chk("R2 cmp hi", 16'(d), 16'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule